// File: doc/BRIEF.md
# Table-Driven Forward Branch Unit

This execution block resolves the compact table-branch instruction of a mixed 16/32-bit instruction set. It is handed a 32-bit instruction word, the address of that instruction, a condition-pass flag and the status of the enclosing conditional block. A start pulse begins the work. The block recognises the encoding and reads a base register and an index register through a small combinational register-read interface. It then fetches an unsigned byte or halfword entry from a memory table through a byte-wide request/valid read port. The result is a forward branch target equal to the current PC plus twice the fetched entry.

The instruction word carries its first halfword in bits 31:16 and its second halfword in bits 15:0. The block supplies the PC value (instruction address + 4) whenever the base selector names the PC. It also flags encodings whose behaviour is not defined, and suppresses both the table read and the branch in that case. Every accepted instruction ends with a one-cycle done strobe. Whether the branch is taken is reported alongside that strobe.

Top module: `tbr_unit`

## Requirements
- R1: The instruction matches only when bits 31:20 = 0xE8D, bits 15:12 = 0xF, bits 11:8 = 0x0 and bits 7:5 = 0b000. The base selector is bits 19:16, the size bit is bit 4 and the index selector is bits 3:0. A non-matching word produces done in the first cycle after start, with no memory request, taken low and unpredictable low.
- R2: With size bit 0, exactly one byte is read, at base + index. The target is (instruction address + 4) + 2 × byte, and target reads zero whenever taken is low.
- R3: With size bit 1, two byte reads are issued: first at base + 2 × index (the low byte), then at that address + 1 (the high byte). The entry is little-endian, and the target is (instruction address + 4) + 2 × entry.
- R4: A base selector of 15 makes the base operand equal to instruction address + 4, whatever the register read returns.
- R5: When cond_pass is low at start, no memory request is issued. Done pulses in the first cycle after start with taken low.
- R6: An index selector of 15 on a matching word raises unpredictable with done. No memory request is issued and taken stays low, whatever the value of cond_pass.
- R7: A matching word with in_cblk high and last_cblk low raises unpredictable, with no request and no branch. With in_cblk and last_cblk both high, the instruction executes normally.
- R8: Define the start edge as cycle 0 and the read latency L (L ≥ 1) as the number of cycles from a request to its valid. The first request appears in cycle 1. A byte fetch gives done in cycle 2 + L. A halfword fetch places its second request in cycle 2 + L and gives done in cycle 3 + 2L. Each request and each done lasts one cycle, and taken is high only together with done.
- R9: All address and target sums wrap modulo 2^32.
- R10: A start pulse that arrives while an instruction is in progress is ignored. It changes neither the requests nor the result, and it produces no extra done.
- R11: While reset is applied, and until the first start, mem_req, done, taken, unpredictable and target are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin processing the presented instruction (taken only when idle) |
| instr | input | 32 | Instruction word, first halfword in 31:16 |
| instr_addr | input | 32 | Address of the instruction |
| cond_pass | input | 1 | Condition check passed |
| in_cblk | input | 1 | Instruction lies inside a conditional block |
| last_cblk | input | 1 | Instruction is the last of its conditional block |
| base_sel | output | 4 | Register number for the base read |
| index_sel | output | 4 | Register number for the index read |
| base_val | input | 32 | Base register value (same cycle as base_sel) |
| index_val | input | 32 | Index register value (same cycle as index_sel) |
| mem_req | output | 1 | One-cycle byte read request |
| mem_addr | output | 32 | Byte address of the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| done | output | 1 | One-cycle completion strobe |
| taken | output | 1 | Branch taken, valid with done |
| target | output | 32 | Branch target, zero unless taken |
| unpred | output | 1 | Unpredictable encoding or placement, valid with done |

## Verification
Two situations are hard to reach from the ports. The first is a halfword entry whose two bytes straddle the top of the address space, which tests the wrap behaviour. The second is a second start that arrives in the middle of a slow fetch. The stimulus places the base at 0xFFFF_FFFF to force the wrap, and it varies the memory latency per instruction. On chosen runs it also raises start again with a different instruction while the first read is still outstanding. The reference then requires the original request schedule and result to appear, with no extra done.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ENTRY_W = 2 * BYTE_W;

  localparam logic [11:0] OPC_HI   = 12'hE8D;
  localparam logic [3:0]  OPC_LO_A = 4'hF;
  localparam logic [3:0]  OPC_LO_B = 4'h0;
  localparam logic [2:0]  OPC_LO_C = 3'b000;
  localparam logic [SEL_W-1:0] PC_SEL = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD_LO = 3'd1,
    ST_WT_LO = 3'd2,
    ST_RD_HI = 3'd3,
    ST_WT_HI = 3'd4,
    ST_FIN   = 3'd5
  } tbr_state_e;

  typedef struct packed {
    logic             hit;
    logic             half;
    logic [SEL_W-1:0] base_sel;
    logic [SEL_W-1:0] index_sel;
    logic             base_is_pc;
    logic             index_is_pc;
  } tbr_dec_t;
endpackage

// File: rtl/tbr_decode.sv
module tbr_decode
  import tbr_pkg::*;
#(
  parameter int unsigned IW = 32
) (
  input  logic [IW-1:0] instr,
  output tbr_dec_t      dec
);
  localparam int unsigned HW = IW / 2;

  logic [HW-1:0] hw_first;
  logic [HW-1:0] hw_second;

  assign hw_first  = instr[IW-1:HW];
  assign hw_second = instr[HW-1:0];

  always_comb begin
    dec.hit = (hw_first[15:4]  == OPC_HI)
            & (hw_second[15:12] == OPC_LO_A)
            & (hw_second[11:8]  == OPC_LO_B)
            & (hw_second[7:5]   == OPC_LO_C);
    dec.half        = hw_second[4];
    dec.base_sel    = hw_first[3:0];
    dec.index_sel   = hw_second[3:0];
    dec.base_is_pc  = (hw_first[3:0]  == PC_SEL);
    dec.index_is_pc = (hw_second[3:0] == PC_SEL);
  end
endmodule

// File: rtl/tbr_agen.sv
module tbr_agen #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] instr_addr,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic          base_is_pc,
  input  logic          half,
  output logic [AW-1:0] pc_ahead,
  output logic [AW-1:0] tbl_addr
);
  localparam logic [AW-1:0] PC_STEP = AW'(4);

  logic [AW-1:0] base_op;
  logic [AW-1:0] index_op;

  assign pc_ahead = instr_addr + PC_STEP;
  assign base_op  = base_is_pc ? pc_ahead : base_val;
  assign index_op = half ? {index_val[AW-2:0], 1'b0} : index_val;
  assign tbl_addr = base_op + index_op;
endmodule

// File: rtl/tbr_seq.sv
module tbr_seq
  import tbr_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  tbr_dec_t          dec,
  input  logic              cond_pass,
  input  logic              in_cblk,
  input  logic              last_cblk,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [AW-1:0]     pc_ahead,
  input  logic              mem_rvalid,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic              done,
  output logic              taken,
  output logic [AW-1:0]     target,
  output logic              unpred
);
  localparam int unsigned PAD_W = AW - ENTRY_W - 1;

  tbr_state_e        state_q, state_d;
  logic [AW-1:0]     addr_q, pc_q;
  logic              half_q, go_q, unp_q;
  logic [BYTE_W-1:0] lo_q, hi_q;

  logic ld_issue, ld_lo, ld_hi;
  logic unp_d, go_d;
  logic [ENTRY_W-1:0] entry;

  assign unp_d = dec.hit & (dec.index_is_pc | (in_cblk & ~last_cblk));
  assign go_d  = dec.hit & cond_pass & ~unp_d;

  always_comb begin
    state_d  = state_q;
    ld_issue = 1'b0;
    ld_lo    = 1'b0;
    ld_hi    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          ld_issue = 1'b1;
          state_d  = go_d ? ST_RD_LO : ST_FIN;
        end
      end
      ST_RD_LO: state_d = ST_WT_LO;
      ST_WT_LO: begin
        if (mem_rvalid) begin
          ld_lo   = 1'b1;
          state_d = half_q ? ST_RD_HI : ST_FIN;
        end
      end
      ST_RD_HI: state_d = ST_WT_HI;
      ST_WT_HI: begin
        if (mem_rvalid) begin
          ld_hi   = 1'b1;
          state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pc_q   <= '0;
      half_q <= 1'b0;
      go_q   <= 1'b0;
      unp_q  <= 1'b0;
    end else if (ld_issue) begin
      addr_q <= tbl_addr;
      pc_q   <= pc_ahead;
      half_q <= dec.half;
      go_q   <= go_d;
      unp_q  <= unp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (ld_lo) begin
      lo_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (ld_issue | ld_hi) begin
      hi_q <= ld_hi ? mem_rdata : '0;
    end
  end

  assign entry    = {hi_q, lo_q};
  assign mem_req  = (state_q == ST_RD_LO) | (state_q == ST_RD_HI);
  assign mem_addr = (state_q == ST_RD_HI) ? addr_q + AW'(1) : addr_q;
  assign done     = (state_q == ST_FIN);
  assign taken    = done & go_q;
  assign unpred   = done & unp_q;
  assign target   = taken ? pc_q + {{PAD_W{1'b0}}, entry, 1'b0} : '0;
endmodule

// File: rtl/tbr_unit.sv
module tbr_unit
  import tbr_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IW-1:0]     instr,
  input  logic [AW-1:0]     instr_addr,
  input  logic              cond_pass,
  input  logic              in_cblk,
  input  logic              last_cblk,
  output logic [SEL_W-1:0]  base_sel,
  output logic [SEL_W-1:0]  index_sel,
  input  logic [AW-1:0]     base_val,
  input  logic [AW-1:0]     index_val,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              done,
  output logic              taken,
  output logic [AW-1:0]     target,
  output logic              unpred
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  tbr_dec_t      dec;
  logic [AW-1:0] pc_ahead;
  logic [AW-1:0] tbl_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  tbr_decode #(.IW(IW)) u_decode (
    .instr (instr),
    .dec   (dec)
  );

  assign base_sel  = dec.base_sel;
  assign index_sel = dec.index_sel;

  tbr_agen #(.AW(AW)) u_agen (
    .instr_addr (instr_addr),
    .base_val   (base_val),
    .index_val  (index_val),
    .base_is_pc (dec.base_is_pc),
    .half       (dec.half),
    .pc_ahead   (pc_ahead),
    .tbl_addr   (tbl_addr)
  );

  tbr_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .dec        (dec),
    .cond_pass  (cond_pass),
    .in_cblk    (in_cblk),
    .last_cblk  (last_cblk),
    .tbl_addr   (tbl_addr),
    .pc_ahead   (pc_ahead),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .done       (done),
    .taken      (taken),
    .target     (target),
    .unpred     (unpred)
  );
endmodule

// File: rtl/tbr_unit_chk.sv
module tbr_unit_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          done,
  input logic          taken,
  input logic          unpred,
  input logic [AW-1:0] target
);
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_REQ_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !done); // R8
  AST_TAKEN_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> done); // R8
  AST_UNPRED_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    unpred |-> (done && !taken)); // R6
  AST_TARGET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> (target == '0)); // R2
endmodule

bind tbr_unit tbr_unit_chk #(.AW(AW)) i_tbr_unit_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mem_req (mem_req),
  .done    (done),
  .taken   (taken),
  .unpred  (unpred),
  .target  (target)
);

// File: tb/test_tbr_unit.sv
module test_tbr_unit;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] instr;
  logic [31:0] instr_addr;
  logic        cond_pass;
  logic        in_cblk;
  logic        last_cblk;
  logic [3:0]  base_sel;
  logic [3:0]  index_sel;
  logic [31:0] base_val;
  logic [31:0] index_val;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [7:0]  mem_rdata;
  logic        done;
  logic        taken;
  logic [31:0] target;
  logic        unpred;

  logic [31:0] regs [16];
  int n_cmp;
  int n_bad;

  assign base_val  = regs[base_sel];
  assign index_val = regs[index_sel];

  tbr_unit i_tbr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .instr_addr(instr_addr), .cond_pass(cond_pass), .in_cblk(in_cblk),
    .last_cblk(last_cblk), .base_sel(base_sel), .index_sel(index_sel),
    .base_val(base_val), .index_val(index_val), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .taken(taken), .target(target), .unpred(unpred)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] mbyte(logic [31:0] a);
    logic [31:0] h;
    h = (a * 32'h9E37_79B1) ^ (a >> 7);
    return h[7:0] ^ h[23:16];
  endfunction

  function automatic logic [31:0] enc(logic [3:0] rn, logic h, logic [3:0] rm);
    return {12'hE8D, rn, 4'hF, 4'h0, 3'b000, h, rm};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // Issue one instruction and compare outputs on every cycle against the model.
  task automatic run(input logic [31:0] iw, input logic [31:0] ia, input bit cp,
                     input bit ib, input bit lb, input int lat, input bit poke,
                     input string tag);
    logic [3:0]  rn, rm;
    logic        h, hit, unp, go;
    logic [31:0] pc4, base, idx, a0, a1, val, tgt;
    int          done_cyc, req2;
    rn  = iw[19:16];
    rm  = iw[3:0];
    h   = iw[4];
    hit = (iw[31:20] == 12'hE8D) && (iw[15:8] == 8'hF0) && (iw[7:5] == 3'b000);
    unp = hit && ((rm == 4'hF) || (ib && !lb));
    go  = hit && cp && !unp;
    pc4 = ia + 32'd4;
    base = (rn == 4'hF) ? pc4 : regs[rn];
    idx  = regs[rm];
    a0  = base + (h ? (idx << 1) : idx);
    a1  = a0 + 32'd1;
    val = h ? {16'h0, mbyte(a1), mbyte(a0)} : {24'h0, mbyte(a0)};
    tgt = pc4 + (val << 1);
    done_cyc = !go ? 1 : (h ? 3 + 2 * lat : 2 + lat);
    req2     = (go && h) ? 2 + lat : -1;

    @(negedge clk);
    instr = iw; instr_addr = ia; cond_pass = cp; in_cblk = ib; last_cblk = lb;
    start = 1'b1;
    for (int k = 1; k <= done_cyc + 2; k++) begin
      @(negedge clk);
      begin
        bit er;
        er = (go && k == 1) || (k == req2);
        chk(mem_req == er, {tag, " R8 req"}, {31'h0, mem_req}, {31'h0, er});
        if (er)
          chk(mem_addr == ((k == 1) ? a0 : a1), {tag, (h ? " R3" : " R2"), " addr"},
              mem_addr, (k == 1) ? a0 : a1);
        chk(done == (k == done_cyc), {tag, " R8 done"}, {31'h0, done},
            {31'h0, k == done_cyc});
        if (k == done_cyc) begin
          chk(taken == go, {tag, " R5 taken"}, {31'h0, taken}, {31'h0, go});
          chk(unpred == unp, {tag, " R6 R7 unpred"}, {31'h0, unpred}, {31'h0, unp});
          chk(target == (go ? tgt : 32'h0), {tag, " R2 R3 R9 target"}, target,
              go ? tgt : 32'h0);
        end else begin
          chk(!taken && !unpred && target == 32'h0, {tag, " R10 quiet"}, target, 32'h0);
        end
      end
      start = 1'b0;
      if (poke && k == 1) begin
        instr = enc(4'h1, 1'b0, 4'h2);
        instr_addr = ia ^ 32'h0000_1000;
        cond_pass = 1'b1;
        start = 1'b1;
      end
      if (go && (k == 1 + lat || (h && k == 2 + 2 * lat))) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mbyte((k == 1 + lat) ? a0 : a1);
      end else begin
        mem_rvalid = 1'b0;
        mem_rdata  = 8'($urandom);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    for (int i = 0; i < 16; i++) regs[i] = 32'h1000 * i + 32'h40 + i;
    rst_n = 1'b0; start = 1'b0; instr = '0; instr_addr = '0; cond_pass = 1'b0;
    in_cblk = 1'b0; last_cblk = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(!mem_req && !done && !taken && !unpred && target == 0, "R11 in reset",
        target, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req && !done && !taken && !unpred && target == 0, "R11 after reset",
        target, 32'h0);

    regs[3] = 32'd5;
    run(enc(4'h2, 1'b0, 4'h3), 32'h0000_8000, 1'b1, 1'b0, 1'b0, 1, 1'b0, "R2 byte L1");
    run(enc(4'h2, 1'b0, 4'h3), 32'h0000_8000, 1'b1, 1'b0, 1'b0, 4, 1'b0, "R2 byte L4");
    run(enc(4'h6, 1'b1, 4'h3), 32'h0000_9002, 1'b1, 1'b0, 1'b0, 1, 1'b0, "R3 half L1");
    run(enc(4'h6, 1'b1, 4'h3), 32'h0000_9002, 1'b1, 1'b0, 1'b0, 3, 1'b0, "R3 half L3");
    run(enc(4'hF, 1'b0, 4'h3), 32'h0000_A000, 1'b1, 1'b0, 1'b0, 2, 1'b0, "R4 pc byte");
    run(enc(4'hF, 1'b1, 4'h3), 32'h0000_A010, 1'b1, 1'b0, 1'b0, 1, 1'b0, "R4 pc half");
    run(enc(4'h2, 1'b1, 4'h3), 32'h0000_8000, 1'b0, 1'b0, 1'b0, 1, 1'b0, "R5 cond off");
    run(enc(4'h2, 1'b0, 4'hF), 32'h0000_8000, 1'b1, 1'b0, 1'b0, 1, 1'b0, "R6 rm15");
    run(enc(4'h2, 1'b1, 4'hF), 32'h0000_8000, 1'b0, 1'b0, 1'b0, 1, 1'b0, "R6 rm15 nocond");
    run(enc(4'h2, 1'b0, 4'h3), 32'h0000_8000, 1'b1, 1'b1, 1'b0, 1, 1'b0, "R7 mid block");
    run(enc(4'h2, 1'b1, 4'h3), 32'h0000_8000, 1'b1, 1'b1, 1'b1, 2, 1'b0, "R7 last block");
    run(enc(4'h2, 1'b0, 4'h3) | 32'h0000_0020, 32'h0, 1'b1, 1'b0, 1'b0, 1, 1'b0, "R1 bit5");
    run(enc(4'h2, 1'b0, 4'h3) ^ 32'h0010_0000 ^ 32'h0002_0000, 32'h0, 1'b1, 1'b0, 1'b0,
        1, 1'b0, "R1 opcode");
    run(enc(4'h2, 1'b0, 4'h3) & 32'hFFFF_7FFF, 32'h0, 1'b1, 1'b0, 1'b0, 1, 1'b0, "R1 bit15");
    regs[7] = 32'hFFFF_FFFF; regs[8] = 32'd0;
    run(enc(4'h7, 1'b1, 4'h8), 32'hFFFF_FF00, 1'b1, 1'b0, 1'b0, 2, 1'b0, "R9 wrap half");
    regs[8] = 32'h8000_0001;
    run(enc(4'h7, 1'b1, 4'h8), 32'hFFFF_FFF8, 1'b1, 1'b0, 1'b0, 1, 1'b0, "R9 wrap idx");
    run(enc(4'h6, 1'b1, 4'h3), 32'h0000_9002, 1'b1, 1'b0, 1'b0, 3, 1'b1, "R10 busy half");
    run(enc(4'h2, 1'b0, 4'h3), 32'h0000_8000, 1'b1, 1'b0, 1'b0, 2, 1'b1, "R10 busy byte");

    for (int t = 0; t < 60; t++) begin
      logic [3:0] rn, rm;
      for (int i = 0; i < 15; i++) regs[i] = $urandom;
      rn = 4'($urandom);
      rm = 4'($urandom_range(0, 15));
      run(enc(rn, 1'($urandom), rm), $urandom & 32'hFFFF_FFFE, 1'($urandom_range(0, 3) != 0),
          1'($urandom), 1'($urandom_range(0, 3) != 0), $urandom_range(1, 5),
          1'($urandom_range(0, 4) == 0), "R2 R3 mix");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule